// File: doc/BRIEF.md
# Chip-Select Window Decoder

This block maps a CPU address onto one of eight external chip-select windows. Each window has its own 12-bit configuration word with a 6-bit base, a 4-bit mask code and an enable flag. A window takes part in decoding only when its enable flag is set and its mask code is one of the accepted codes. For such a window, address bits [29:24] are compared with the base. Only the bit positions that the mask keeps are compared.

When one or more windows match, the lowest-numbered one claims the access. The decoder then reports three things: the winning chip select, the window size in bytes, and the byte offset inside that window. It also picks a destination path. A window marked as a NOR-style memory goes to the memory path. A window marked as a NAND-style device goes to the prefetch FIFO when the prefetch engine is enabled and points at that chip select, and to the plain NAND port otherwise. An access that matches no window raises a miss flag.

The results are registered, so they appear one clock after the request is presented. The configuration words are written through a small write port and can be read back through a combinational read port.

Top module: `csw_decoder`

## Requirements
- R1: A configuration write stores only the bits selected by 0xF7F (base [5:0], enable bit 6, mask code [11:8]); bit 7 always reads back as 0.
- R2: After reset, every configuration word reads 0xF00, except chip select 0, which reads 0xF40 (enabled, base 0, mask code 0xF).
- R3: A window whose enable bit is clear never claims an access.
- R4: Mask codes 0x8, 0xC, 0xE and 0xF are accepted. Any other nonzero code leaves the window unmapped.
- R5: Mask code 0x0 is accepted as a 256 MB window only while `allow_full_span` is 1. Otherwise that window is unmapped.
- R6: A window matches when address bits [29:28] equal base bits [5:4] and, for each mask bit k that is 1, address bit 24+k equals base bit k.
- R7: `dec_size` equals ((0x0FFFFFFF & ~(mask << 24)) + 1). This gives 128, 64, 32, 16 and 256 MB for codes 0x8, 0xC, 0xE, 0xF and 0x0.
- R8: The route code is 2'b01 (memory) for a winning chip select whose `cs_is_nand` bit is 0.
- R9: For a NAND-type winner, the route code is 2'b11 (prefetch FIFO) when `pf_en` is 1 and `pf_cs` equals the winner. In every other case it is 2'b10 (NAND port).
- R10: When several windows match, the lowest-numbered chip select wins.
- R11: A request that matches no window gives `dec_miss`=1, `dec_valid`=0 and route 2'b00. Without a request, both flags are 0.
- R12: Results appear on the outputs one clock after the request is sampled, with `dec_offset` = address bits [27:0] AND (`dec_size` - 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wsel | input | 3 | Chip select being written |
| cfg_wdata | input | 12 | Configuration write data |
| cfg_rsel | input | 3 | Chip select being read |
| cfg_rdata | output | 12 | Configuration word of `cfg_rsel` |
| cs_is_nand | input | 8 | Per chip select: 1 = NAND-type device, 0 = NOR-type memory |
| pf_en | input | 1 | Prefetch engine enabled |
| pf_cs | input | 3 | Chip select served by the prefetch engine |
| allow_full_span | input | 1 | Accept mask code 0x0 as a 256 MB window |
| acc_valid | input | 1 | Address request present |
| acc_addr | input | 32 | Request address |
| dec_valid | output | 1 | Registered: a window claimed the request |
| dec_miss | output | 1 | Registered: request matched no window |
| dec_cs | output | 3 | Winning chip select |
| dec_route | output | 2 | 00 none, 01 memory, 10 NAND port, 11 prefetch FIFO |
| dec_size | output | 29 | Window size in bytes |
| dec_offset | output | 28 | Byte offset inside the window |

## Verification
The decoder is driven with addresses aimed at windows of each accepted mask code. These runs separate the compared bit positions from the ignored ones, and each gives a different size and offset. Addresses aimed at disabled windows, at windows with an illegal code, and at a mask-0 window with the full-span input at both values show whether the acceptance rules actually gate the match. Two windows with the same base are then disabled one at a time to expose the priority order. The device-type and prefetch inputs are toggled against a fixed hit to tell the three routes apart.

// File: rtl/csw_pkg.sv
package csw_pkg;

  localparam int BASE_W    = 6;
  localparam int MASK_W    = 4;
  localparam int WIN_LSB   = 24;
  localparam int CFG_W     = 12;
  localparam int EN_BIT    = 6;
  localparam int MASK_LSB  = 8;
  localparam int SPAN_W    = MASK_W + WIN_LSB;
  localparam int SIZE_W    = SPAN_W + 1;
  localparam logic [CFG_W-1:0] CFG_KEEP = 12'hF7F;
  localparam logic [CFG_W-1:0] CFG_RST  = 12'hF00;

  typedef enum logic [1:0] {
    RT_NONE = 2'b00,
    RT_MEM  = 2'b01,
    RT_NAND = 2'b10,
    RT_FIFO = 2'b11
  } route_e;

  function automatic logic [BASE_W-1:0] cfg_base(input logic [CFG_W-1:0] c);
    return c[BASE_W-1:0];
  endfunction

  function automatic logic [MASK_W-1:0] cfg_mask(input logic [CFG_W-1:0] c);
    return c[MASK_LSB +: MASK_W];
  endfunction

  function automatic logic cfg_en(input logic [CFG_W-1:0] c);
    return c[EN_BIT];
  endfunction

  function automatic logic mask_ok(input logic [MASK_W-1:0] m, input logic full_ok);
    logic fixed;
    fixed = (m == 4'h8) || (m == 4'hC) || (m == 4'hE) || (m == 4'hF);
    return fixed || ((m == '0) && full_ok);
  endfunction

  function automatic logic [BASE_W-1:0] cmp_sel(input logic [MASK_W-1:0] m);
    return {{(BASE_W-MASK_W){1'b1}}, m};
  endfunction

  function automatic logic [SIZE_W-1:0] span_bytes(input logic [MASK_W-1:0] m);
    logic [SIZE_W-1:0] lim;
    lim = {1'b0, ~m, {WIN_LSB{1'b1}}};
    return lim + SIZE_W'(1);
  endfunction

endpackage

// File: rtl/cs_cfg_bank.sv
module cs_cfg_bank
  import csw_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int SEL_W  = $clog2(NUM_CS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  logic [CFG_W-1:0] wdata,
  input  logic [SEL_W-1:0] rsel,
  output logic [CFG_W-1:0] rdata,
  output logic [CFG_W-1:0] cfg_q [NUM_CS]
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_word
    localparam logic [CFG_W-1:0] RST_V =
      (i == 0) ? (CFG_RST | (CFG_W'(1) << EN_BIT)) : CFG_RST;
    logic hit_w;
    assign hit_w = we && (wsel == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)     cfg_q[i] <= RST_V;
      else if (hit_w) cfg_q[i] <= wdata & CFG_KEEP;
    end

    a_r1_gap_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hit_w) |-> (cfg_q[i][7] == 1'b0));
  end

  assign rdata = cfg_q[rsel];

endmodule

// File: rtl/cs_window_match.sv
module cs_window_match
  import csw_pkg::*;
#(
  parameter int NUM_CS = 8
) (
  input  logic [CFG_W-1:0]  cfg_q [NUM_CS],
  input  logic [BASE_W-1:0] addr_field,
  input  logic              full_ok,
  output logic [NUM_CS-1:0] hit_vec
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_win
    logic [MASK_W-1:0] m;
    logic [BASE_W-1:0] diff;
    logic              legal;
    assign m     = cfg_mask(cfg_q[i]);
    assign legal = mask_ok(m, full_ok);
    assign diff  = (addr_field ^ cfg_base(cfg_q[i])) & cmp_sel(m);
    assign hit_vec[i] = cfg_en(cfg_q[i]) && legal && (diff == '0);
  end

endmodule

// File: rtl/cs_route_sel.sv
module cs_route_sel
  import csw_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int SEL_W  = $clog2(NUM_CS)
) (
  input  logic [NUM_CS-1:0] hit_vec,
  input  logic [CFG_W-1:0]  cfg_q [NUM_CS],
  input  logic [NUM_CS-1:0] is_nand,
  input  logic              pf_en,
  input  logic [SEL_W-1:0]  pf_cs,
  output logic              any_hit,
  output logic [SEL_W-1:0]  win_cs,
  output route_e            route,
  output logic [SIZE_W-1:0] size
);

  always_comb begin
    win_cs = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_cs = SEL_W'(i);
    end
  end

  assign any_hit = |hit_vec;
  assign size    = span_bytes(cfg_mask(cfg_q[win_cs]));

  always_comb begin
    if (!any_hit)                      route = RT_NONE;
    else if (!is_nand[win_cs])         route = RT_MEM;
    else if (pf_en && (pf_cs == win_cs)) route = RT_FIFO;
    else                               route = RT_NAND;
  end

endmodule

// File: rtl/csw_decoder.sv
module csw_decoder
  import csw_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 32,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_wsel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [SEL_W-1:0]  cfg_rsel,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [NUM_CS-1:0] cs_is_nand,
  input  logic              pf_en,
  input  logic [SEL_W-1:0]  pf_cs,
  input  logic              allow_full_span,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              dec_valid,
  output logic              dec_miss,
  output logic [SEL_W-1:0]  dec_cs,
  output logic [1:0]        dec_route,
  output logic [SIZE_W-1:0] dec_size,
  output logic [SPAN_W-1:0] dec_offset
);

  localparam int FIELD_HI = WIN_LSB + BASE_W - 1;

  logic [CFG_W-1:0]  cfg_q [NUM_CS];
  logic [NUM_CS-1:0] hit_vec;
  logic              sel_any;
  logic [SEL_W-1:0]  sel_cs;
  route_e            sel_route;
  logic [SIZE_W-1:0] sel_size;
  logic [SPAN_W-1:0] sel_off;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^acc_addr[ADDR_W-1:FIELD_HI+1];

  cs_cfg_bank #(.NUM_CS(NUM_CS)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wsel(cfg_wsel),
    .wdata(cfg_wdata), .rsel(cfg_rsel), .rdata(cfg_rdata), .cfg_q(cfg_q)
  );

  cs_window_match #(.NUM_CS(NUM_CS)) u_match (
    .cfg_q(cfg_q), .addr_field(acc_addr[FIELD_HI:WIN_LSB]),
    .full_ok(allow_full_span), .hit_vec(hit_vec)
  );

  cs_route_sel #(.NUM_CS(NUM_CS)) u_route (
    .hit_vec(hit_vec), .cfg_q(cfg_q), .is_nand(cs_is_nand),
    .pf_en(pf_en), .pf_cs(pf_cs), .any_hit(sel_any),
    .win_cs(sel_cs), .route(sel_route), .size(sel_size)
  );

  assign sel_off = acc_addr[SPAN_W-1:0] & SPAN_W'(sel_size - SIZE_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_miss   <= 1'b0;
      dec_cs     <= '0;
      dec_route  <= RT_NONE;
      dec_size   <= '0;
      dec_offset <= '0;
    end else begin
      dec_valid  <= acc_valid && sel_any;
      dec_miss   <= acc_valid && !sel_any;
      dec_cs     <= acc_valid ? sel_cs : '0;
      dec_route  <= acc_valid ? sel_route : RT_NONE;
      dec_size   <= (acc_valid && sel_any) ? sel_size : '0;
      dec_offset <= (acc_valid && sel_any) ? sel_off : '0;
    end
  end

  a_r10_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sel_any |-> (hit_vec[sel_cs] &&
                 ((hit_vec & ((NUM_CS'(1) << sel_cs) - NUM_CS'(1))) == '0)));

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_valid && dec_miss));

  a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (dec_valid || dec_miss));

  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!dec_valid && !dec_miss));

  a_r7_size_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ($countones(dec_size) == 1));

  a_r12_offset_inside: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ({1'b0, dec_offset} < dec_size));

  a_r9_fifo_target: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_route == RT_FIFO) |-> ($past(pf_en) && ($past(pf_cs) == dec_cs)));

  a_r8_mem_is_nor: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_route == RT_MEM) |-> !($past(cs_is_nand) >> dec_cs) & 1'b1);

endmodule

// File: tb/csw_decoder_test.sv
module csw_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_wsel = '0;
  logic [11:0] cfg_wdata = '0;
  logic [2:0]  cfg_rsel = '0;
  logic [11:0] cfg_rdata;
  logic [7:0]  cs_is_nand = '0;
  logic        pf_en = 1'b0;
  logic [2:0]  pf_cs = '0;
  logic        allow_full_span = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        dec_valid, dec_miss;
  logic [2:0]  dec_cs;
  logic [1:0]  dec_route;
  logic [28:0] dec_size;
  logic [27:0] dec_offset;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  csw_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wsel(cfg_wsel),
    .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .cs_is_nand(cs_is_nand), .pf_en(pf_en), .pf_cs(pf_cs),
    .allow_full_span(allow_full_span), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .dec_valid(dec_valid), .dec_miss(dec_miss), .dec_cs(dec_cs),
    .dec_route(dec_route), .dec_size(dec_size), .dec_offset(dec_offset)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [2:0] cs, input logic [11:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wsel = cs; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] cs, input logic [11:0] exp);
    cfg_rsel = cs;
    #1;
    chk(req, "cfg readback", cfg_rdata, exp);
  endtask

  task automatic do_access(input logic [31:0] a);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] a, input logic [2:0] cs,
                            input logic [1:0] rt, input logic [28:0] sz,
                            input logic [27:0] off);
    do_access(a);
    chk(req, "dec_valid", dec_valid, 1'b1);
    chk(req, "dec_miss", dec_miss, 1'b0);
    chk(req, "dec_cs", dec_cs, cs);
    chk(req, "dec_route", dec_route, rt);
    chk(req, "dec_size", dec_size, sz);
    chk(req, "dec_offset", dec_offset, off);
  endtask

  task automatic expect_miss(input string req, input logic [31:0] a);
    do_access(a);
    chk(req, "dec_valid", dec_valid, 1'b0);
    chk(req, "dec_miss", dec_miss, 1'b1);
    chk(req, "dec_route", dec_route, 2'b00);
  endtask

  // R2: reset values; R11: idle outputs
  task automatic t_reset;
    rd_chk("R2", 3'd0, 12'hF40);
    for (int i = 1; i < 8; i++) rd_chk("R2", 3'(i), 12'hF00);
    chk("R11", "idle valid", dec_valid, 1'b0);
    chk("R11", "idle miss", dec_miss, 1'b0);
    expect_hit("R2", 32'h0012_3456, 3'd0, 2'b01, 29'h100_0000, 28'h012_3456);
    expect_miss("R11", 32'h0100_0000);
  endtask

  // R1: write keep mask
  task automatic t_write_mask;
    wr_cfg(3'd3, 12'hFFF);
    rd_chk("R1", 3'd3, 12'hF7F);
    wr_cfg(3'd3, 12'h080);
    rd_chk("R1", 3'd3, 12'h000);
  endtask

  // R4, R6, R7, R12: each accepted code
  task automatic t_masks;
    wr_cfg(3'd1, 12'h848);
    wr_cfg(3'd2, 12'hC54);
    wr_cfg(3'd4, 12'hE62);
    expect_hit("R4", 32'h0D00_0000, 3'd1, 2'b01, 29'h800_0000, 28'h500_0000);
    expect_hit("R6", 32'h15AB_CDEF, 3'd2, 2'b01, 29'h400_0000, 28'h1AB_CDEF);
    expect_hit("R7", 32'h2300_0010, 3'd4, 2'b01, 29'h200_0000, 28'h100_0010);
    expect_miss("R6", 32'h0500_0000);
    expect_miss("R6", 32'h1900_0000);
    wr_cfg(3'd5, 12'h470);
    expect_miss("R4", 32'h3000_0000);
    wr_cfg(3'd5, 12'h170);
    expect_miss("R4", 32'h3000_0000);
  endtask

  // R3: enable bit gates decode
  task automatic t_enable;
    wr_cfg(3'd6, 12'hF31);
    expect_miss("R3", 32'h3100_0040);
    wr_cfg(3'd6, 12'hF71);
    expect_hit("R3", 32'h3100_0040, 3'd6, 2'b01, 29'h100_0000, 28'h000_0040);
  endtask

  // R5: full-span code
  task automatic t_full_span;
    wr_cfg(3'd7, 12'h078);
    allow_full_span = 1'b0;
    expect_miss("R5", 32'h3A00_0000);
    allow_full_span = 1'b1;
    expect_hit("R5", 32'h3A00_0000, 3'd7, 2'b01, 29'h1000_0000, 28'hA00_0000);
    allow_full_span = 1'b0;
  endtask

  // R10: priority
  task automatic t_priority;
    wr_cfg(3'd3, 12'hF40);
    expect_hit("R10", 32'h0000_0100, 3'd0, 2'b01, 29'h100_0000, 28'h000_0100);
    wr_cfg(3'd0, 12'hF00);
    expect_hit("R10", 32'h0000_0100, 3'd3, 2'b01, 29'h100_0000, 28'h000_0100);
  endtask

  // R8, R9: routing
  task automatic t_route;
    cs_is_nand = 8'b0000_1000;
    expect_hit("R9", 32'h0000_0200, 3'd3, 2'b10, 29'h100_0000, 28'h000_0200);
    pf_en = 1'b1; pf_cs = 3'd3;
    expect_hit("R9", 32'h0000_0200, 3'd3, 2'b11, 29'h100_0000, 28'h000_0200);
    pf_cs = 3'd2;
    expect_hit("R9", 32'h0000_0200, 3'd3, 2'b10, 29'h100_0000, 28'h000_0200);
    pf_cs = 3'd3; cs_is_nand = 8'b0000_0000;
    expect_hit("R8", 32'h0000_0200, 3'd3, 2'b01, 29'h100_0000, 28'h000_0200);
    pf_en = 1'b0;
  endtask

  // R12: latency of one clock
  task automatic t_latency;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 32'h0000_0300;
    #2;
    chk("R12", "valid before edge", dec_valid, 1'b0);
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R12", "valid after edge", dec_valid, 1'b1);
    @(negedge clk);
    chk("R12", "valid dropped", dec_valid, 1'b0);
    chk("R11", "miss idle", dec_miss, 1'b0);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_mask();
    t_masks();
    t_enable();
    t_full_span();
    t_priority();
    t_route();
    t_latency();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule